// File: doc/BRIEF.md
# Video Sync and Clamp Timing Generator

This block sits in the pixel-clock domain of a three-channel video digitizer front end. It takes a raw horizontal sync input, an optional external clamp strobe and an optional coast strobe, and derives from them the control timing the rest of the front end needs. That timing is a one-cycle leading-edge strobe, a regenerated horizontal sync of programmable polarity and width, a clamp window for the input restoration circuits, and a coast flag that tells the pixel clock generator to hold frequency and phase.

The sync input is sensed on one edge only, chosen by a polarity setting. The clamp window comes from one of two sources. It can be timed internally by a delay counter and a duration counter started from the sync trailing edge. It can also be taken directly from the external clamp pin, read with a selectable polarity. All configuration arrives as static input ports driven by a register file elsewhere. The register file is expected to reset the coast polarity to 1, which makes the coast pin active-high.

Top module: `vsc_timing_top`

## Requirements
- R1: While reset is high, `hs_lead` and `hs_ref` are 0, `clamp_on` is 0 when the internal clamp source is selected, and `hsout` sits at its inactive level, which is the inverse of `cfg_hsout_pol`.
- R2: Every input pin passes through two synchronizing flops. A sync-pin change first sampled at clock edge n raises `hs_lead` for exactly one cycle, the cycle after edge n+1, but only when the change is the leading edge. With `cfg_hs_pol`=1 the leading edge is a 0→1 change; with 0 it is a 1→0 change.
- R3: The trailing edge of the sync pin produces no `hs_lead`. It neither starts nor restarts `hsout`.
- R4: After an `hs_lead` cycle, `hsout` is at level `cfg_hsout_pol` for exactly `cfg_hsout_wid` cycles and is at the inverse level otherwise. A width of 0 gives no pulse. A new leading edge reloads the full width.
- R5: With `cfg_clamp_ext`=0, let c be the cycle in which a trailing edge is detected (same timing as R2). `clamp_on` is then high in cycles c+1+D through c+D+L, where D=`cfg_clamp_dly` and L=`cfg_clamp_len`.
- R6: With `cfg_clamp_len`=0, the internal source produces no clamp pulse.
- R7: A trailing edge that arrives while a delay is counting or a window is open restarts the delay and closes the open window. A delay longer than the sync period therefore never opens a window.
- R8: With `cfg_clamp_ext`=1, `clamp_on` is 1 exactly when the synchronized clamp pin equals `cfg_clamp_pol`. A pin sample taken at edge n shows in the cycle after edge n+1.
- R9: With `cfg_clamp_ext`=0, the clamp pin has no effect on `clamp_on`.
- R10: `coast_on` is 1 exactly when the synchronized coast pin equals `cfg_coast_pol`, with the same latency as R8.
- R11: `hs_ref` equals `hs_lead` while `coast_on` is 0 and is held at 0 while `coast_on` is 1. `hsout` keeps being regenerated during coast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync pin |
| clamp_in | input | 1 | External clamp strobe pin |
| coast_in | input | 1 | Coast request pin |
| cfg_hs_pol | input | 1 | Sync leading edge: 1 rising, 0 falling |
| cfg_clamp_ext | input | 1 | Clamp source: 1 external pin, 0 internal counters |
| cfg_clamp_pol | input | 1 | Active level of the clamp pin |
| cfg_coast_pol | input | 1 | Active level of the coast pin |
| cfg_clamp_dly | input | 8 | Internal clamp delay in pixel clocks |
| cfg_clamp_len | input | 8 | Internal clamp duration in pixel clocks |
| cfg_hsout_pol | input | 1 | Active level of the regenerated sync |
| cfg_hsout_wid | input | 8 | Regenerated sync width in pixel clocks |
| hs_lead | output | 1 | One-cycle leading-edge strobe |
| hs_ref | output | 1 | Leading-edge strobe for the clock generator, blanked during coast |
| hsout | output | 1 | Regenerated horizontal sync |
| clamp_on | output | 1 | Clamp window active |
| coast_on | output | 1 | Coast active, clock generator holds |

## Verification
The bench builds the block with its defaults: 8-bit delay, duration and width counters and a two-flop synchronizer. The 8-bit range lets a clamp delay of 60 cycles run against a sync period of 40, so the restart-before-window case and the cut-short window case can both be reached. A hsout width longer than the sync period exercises the reload. Coast windows that cover missing sync pulses are run with both coast polarities. The clamp pin is toggled in both source modes under both clamp polarities.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    localparam int CNT_W       = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CLP_IDLE = 2'd0,
        CLP_WAIT = 2'd1,
        CLP_ON   = 2'd2
    } clamp_st_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } hs_edge_t;

    // Classify a synchronized transition by the selected leading polarity
    function automatic hs_edge_t find_edges(input logic pol, input logic now_l, input logic was_l);
        hs_edge_t e;
        e.lead  = pol ? (now_l & ~was_l) : (~now_l & was_l);
        e.trail = pol ? (~now_l & was_l) : (now_l & ~was_l);
        return e;
    endfunction
endpackage

// File: rtl/vsc_sync.sv
module vsc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] stg [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q   = stg[STAGES-1];
    assign q_d = stg[STAGES];
endmodule

// File: rtl/vsc_hsout.sv
module vsc_hsout #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lead,
    input  logic             pol,
    input  logic [CNT_W-1:0] wid,
    output logic             hsout,
    output logic             active
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (lead)        cnt <= wid;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assign active = (cnt != '0);
    assign hsout  = active ? pol : ~pol;

    // R4: a leading edge opens a pulse exactly when the width is nonzero
    assert_hsout_start_R4: assert property (@(posedge clk) disable iff (rst)
        lead |=> (active == ($past(wid) != '0)));

    // R3: without a leading edge an idle output stays idle
    assert_trail_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!lead && !active) |=> !active);
endmodule

// File: rtl/vsc_clamp.sv
module vsc_clamp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trail,
    input  logic [CNT_W-1:0] dly,
    input  logic [CNT_W-1:0] len,
    output logic             win
);
    import vsc_pkg::*;

    clamp_st_t        st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CLP_IDLE;
            cnt <= '0;
        end else if (trail) begin
            if (len == '0) begin
                st <= CLP_IDLE;
            end else if (dly == '0) begin
                st  <= CLP_ON;
                cnt <= len;
            end else begin
                st  <= CLP_WAIT;
                cnt <= dly;
            end
        end else begin
            unique case (st)
                CLP_WAIT: begin
                    if (cnt == CNT_W'(1)) begin
                        if (len == '0) st <= CLP_IDLE;
                        else begin
                            st  <= CLP_ON;
                            cnt <= len;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                CLP_ON: begin
                    if (cnt == CNT_W'(1)) st <= CLP_IDLE;
                    else                  cnt <= cnt - CNT_W'(1);
                end
                default: st <= CLP_IDLE;
            endcase
        end
    end

    assign win = (st == CLP_ON);

    // R6: a zero duration never opens a window
    assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
        (trail && len == '0) |=> !win);

    // R7: a trailing edge with nonzero delay closes any open window
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (trail && dly != '0) |=> !win);
endmodule

// File: rtl/vsc_timing_top.sv
module vsc_timing_top (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_in,
    input  logic       clamp_in,
    input  logic       coast_in,
    input  logic       cfg_hs_pol,
    input  logic       cfg_clamp_ext,
    input  logic       cfg_clamp_pol,
    input  logic       cfg_coast_pol,
    input  logic [7:0] cfg_clamp_dly,
    input  logic [7:0] cfg_clamp_len,
    input  logic       cfg_hsout_pol,
    input  logic [7:0] cfg_hsout_wid,
    output logic       hs_lead,
    output logic       hs_ref,
    output logic       hsout,
    output logic       clamp_on,
    output logic       coast_on
);
    import vsc_pkg::*;

    localparam int PIN_N = 3;
    localparam int I_HS  = 0;
    localparam int I_CL  = 1;
    localparam int I_CO  = 2;

    logic [PIN_N-1:0] pin_q, pin_qd;
    hs_edge_t         edg;
    logic             clamp_int, clamp_ext, hs_busy;

    vsc_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({coast_in, clamp_in, hsync_in}),
        .q   (pin_q),
        .q_d (pin_qd)
    );

    assign edg = find_edges(cfg_hs_pol, pin_q[I_HS], pin_qd[I_HS]);

    vsc_hsout #(.CNT_W(CNT_W)) u_hsout (
        .clk    (clk),
        .rst    (rst),
        .lead   (edg.lead),
        .pol    (cfg_hsout_pol),
        .wid    (cfg_hsout_wid),
        .hsout  (hsout),
        .active (hs_busy)
    );

    vsc_clamp #(.CNT_W(CNT_W)) u_clamp (
        .clk   (clk),
        .rst   (rst),
        .trail (edg.trail),
        .dly   (cfg_clamp_dly),
        .len   (cfg_clamp_len),
        .win   (clamp_int)
    );

    assign clamp_ext = (pin_q[I_CL] == cfg_clamp_pol);
    assign clamp_on  = cfg_clamp_ext ? clamp_ext : clamp_int;
    assign coast_on  = (pin_q[I_CO] == cfg_coast_pol);
    assign hs_lead   = edg.lead;
    assign hs_ref    = edg.lead & ~coast_on;

    // R2: the leading-edge strobe never lasts more than one cycle
    assert_lead_single_R2: assert property (@(posedge clk) disable iff (rst)
        hs_lead |=> !hs_lead);
endmodule

// File: tb/vsc_timing_top_tb.sv
module vsc_timing_top_tb;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0, clamp_in = 1'b0, coast_in = 1'b0;
    logic       cfg_hs_pol = 1'b1, cfg_clamp_ext = 1'b0, cfg_clamp_pol = 1'b1, cfg_coast_pol = 1'b1;
    logic [7:0] cfg_clamp_dly = 8'd3, cfg_clamp_len = 8'd4;
    logic       cfg_hsout_pol = 1'b1;
    logic [7:0] cfg_hsout_wid = 8'd5;
    logic       hs_lead, hs_ref, hsout, clamp_on, coast_on;

    vsc_timing_top u_dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .clamp_in(clamp_in), .coast_in(coast_in),
        .cfg_hs_pol(cfg_hs_pol), .cfg_clamp_ext(cfg_clamp_ext), .cfg_clamp_pol(cfg_clamp_pol),
        .cfg_coast_pol(cfg_coast_pol), .cfg_clamp_dly(cfg_clamp_dly), .cfg_clamp_len(cfg_clamp_len),
        .cfg_hsout_pol(cfg_hsout_pol), .cfg_hsout_wid(cfg_hsout_wid),
        .hs_lead(hs_lead), .hs_ref(hs_ref), .hsout(hsout), .clamp_on(clamp_on), .coast_on(coast_on)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    n_chk = 0, n_bad = 0;
    bit    chk_en = 1'b0;
    string hs_tag = "R4";
    string cl_tag = "R5";

    task automatic chk(string rq, logic got, logic exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", rq, what, $time, got, exp);
        end
    endtask

    // Reference model built from the requirement timing
    logic h1, h2, h3, c1, c2, k1, k2;
    int   m_hcnt, m_st, m_ccnt;

    function automatic bit lead_of(bit pol, bit nw, bit od);
        return pol ? (nw && !od) : (!nw && od);
    endfunction
    function automatic bit trail_of(bit pol, bit nw, bit od);
        return pol ? (!nw && od) : (nw && !od);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            h1 = 0; h2 = 0; h3 = 0; c1 = 0; c2 = 0; k1 = 0; k2 = 0;
            m_hcnt = 0; m_st = 0; m_ccnt = 0;
        end else begin
            bit lp, tp;
            lp = lead_of(cfg_hs_pol, h2, h3);
            tp = trail_of(cfg_hs_pol, h2, h3);
            if (lp) m_hcnt = int'(cfg_hsout_wid);
            else if (m_hcnt != 0) m_hcnt--;
            if (tp) begin
                if (cfg_clamp_len == 0) m_st = 0;
                else if (cfg_clamp_dly == 0) begin m_st = 2; m_ccnt = int'(cfg_clamp_len); end
                else begin m_st = 1; m_ccnt = int'(cfg_clamp_dly); end
            end else if (m_st == 1) begin
                if (m_ccnt == 1) begin
                    if (cfg_clamp_len == 0) m_st = 0;
                    else begin m_st = 2; m_ccnt = int'(cfg_clamp_len); end
                end else m_ccnt--;
            end else if (m_st == 2) begin
                if (m_ccnt == 1) m_st = 0;
                else m_ccnt--;
            end
            h3 = h2; h2 = h1; h1 = hsync_in;
            c2 = c1; c1 = clamp_in;
            k2 = k1; k1 = coast_in;
        end
    end

    always @(negedge clk) begin
        if (chk_en && !rst) begin
            bit el, ec;
            el = lead_of(cfg_hs_pol, h2, h3);
            ec = (k2 == cfg_coast_pol);
            chk("R2", hs_lead, el, "hs_lead");
            chk(hs_tag, hsout, (m_hcnt != 0) ? cfg_hsout_pol : !cfg_hsout_pol, "hsout");
            chk(cfg_clamp_ext ? "R8" : cl_tag, clamp_on,
                cfg_clamp_ext ? (c2 == cfg_clamp_pol) : (m_st == 2), "clamp_on");
            chk("R10", coast_on, ec, "coast_on");
            chk("R11", hs_ref, el && !ec, "hs_ref");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int count, int period, int width, bit act);
        for (int i = 0; i < count; i++) begin
            hsync_in = act;  cyc(width);
            hsync_in = !act; cyc(period - width);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        cyc(3);
        chk("R1", hs_lead, 1'b0, "hs_lead in reset");
        chk("R1", hs_ref, 1'b0, "hs_ref in reset");
        chk("R1", clamp_on, 1'b0, "clamp_on in reset");
        chk("R1", hsout, 1'b0, "hsout in reset pol1");
        cfg_hsout_pol = 1'b0;
        cyc(1);
        chk("R1", hsout, 1'b1, "hsout in reset pol0");
        cfg_hsout_pol = 1'b1;
        rst = 1'b0; chk_en = 1'b1;
        cyc(5);

        // R2: rising leading edge
        cfg_hs_pol = 1'b1;
        pulses(20, 40, 6, 1'b1);

        // R3: falling leading edge, trailing edge long after pulse
        hs_tag = "R3";
        cfg_hs_pol = 1'b0; hsync_in = 1'b1; cyc(10);
        pulses(15, 50, 30, 1'b0);
        cfg_hsout_wid = 8'd12;
        pulses(15, 50, 4, 1'b0);

        // R4: inverted output, zero width, width longer than period
        hs_tag = "R4";
        cfg_hsout_pol = 1'b0;
        cfg_hsout_wid = 8'd0;  pulses(8, 30, 5, 1'b0);
        cfg_hsout_wid = 8'd45; pulses(10, 30, 5, 1'b0);
        cfg_hsout_wid = 8'd1;  pulses(8, 30, 5, 1'b0);
        cfg_hsout_pol = 1'b1;  cfg_hsout_wid = 8'd7;

        // R5: internal window with zero and nonzero delay
        cl_tag = "R5";
        cfg_hs_pol = 1'b1; hsync_in = 1'b0; cyc(10);
        cfg_clamp_dly = 8'd0;  cfg_clamp_len = 8'd7; pulses(10, 40, 5, 1'b1);
        cfg_clamp_dly = 8'd10; cfg_clamp_len = 8'd1; pulses(10, 40, 5, 1'b1);

        // R6: zero duration
        cl_tag = "R6";
        cfg_clamp_dly = 8'd2; cfg_clamp_len = 8'd0; pulses(10, 40, 5, 1'b1);

        // R7: delay beyond next sync edge, then window cut short
        cl_tag = "R7";
        cfg_clamp_dly = 8'd60; cfg_clamp_len = 8'd5;  pulses(12, 40, 5, 1'b1);
        cfg_clamp_dly = 8'd30; cfg_clamp_len = 8'd20; pulses(12, 40, 5, 1'b1);
        cfg_clamp_dly = 8'd0;  cfg_clamp_len = 8'd80; pulses(6, 40, 5, 1'b1);

        // R8: external clamp, both polarities
        cfg_clamp_ext = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cfg_clamp_pol = p[0];
            for (int i = 0; i < 400; i++) begin
                if ($urandom % 5 == 0) clamp_in = !clamp_in;
                if (i % 40 == 0) hsync_in = 1'b1;
                if (i % 40 == 6) hsync_in = 1'b0;
                cyc(1);
            end
        end

        // R9: pin ignored in internal mode
        cfg_clamp_ext = 1'b0; cl_tag = "R9";
        cfg_clamp_dly = 8'd4; cfg_clamp_len = 8'd6;
        for (int p = 0; p < 2; p++) begin
            cfg_clamp_pol = p[0];
            for (int i = 0; i < 400; i++) begin
                if ($urandom % 3 == 0) clamp_in = !clamp_in;
                if (i % 40 == 0) hsync_in = 1'b1;
                if (i % 40 == 6) hsync_in = 1'b0;
                cyc(1);
            end
        end

        // R10 / R11: coast over missing sync pulses, both polarities
        cl_tag = "R5";
        for (int p = 1; p >= 0; p--) begin
            cfg_coast_pol = p[0];
            coast_in = !p[0]; pulses(5, 40, 5, 1'b1);
            coast_in = p[0];  pulses(2, 40, 5, 1'b1);
            cyc(120);
            pulses(2, 40, 5, 1'b1);
            coast_in = !p[0]; pulses(5, 40, 5, 1'b1);
        end
        cfg_coast_pol = 1'b1;

        // Random mix over all settings
        for (int r = 0; r < 12; r++) begin
            cfg_hs_pol    = 1'($urandom);
            cfg_clamp_ext = 1'($urandom);
            cfg_clamp_pol = 1'($urandom);
            cfg_coast_pol = 1'($urandom);
            cfg_hsout_pol = 1'($urandom);
            cfg_clamp_dly = 8'($urandom % 50);
            cfg_clamp_len = 8'($urandom % 30);
            cfg_hsout_wid = 8'($urandom % 40);
            for (int i = 0; i < 600; i++) begin
                if ($urandom % 25 == 0) hsync_in = !hsync_in;
                if ($urandom % 9 == 0)  clamp_in = !clamp_in;
                if ($urandom % 80 == 0) coast_in = !coast_in;
                cyc(1);
            end
        end

        chk_en = 1'b0;
        cyc(2);
        summary();
        $finish;
    end
endmodule